// File: doc/BRIEF.md
# Dual Counter Capture Unit

This block holds two 8-bit timer counters, A and B, that count up or down and wrap around. They can run as two separate counters or be chained into one 16-bit counter. Software can load each counter and can always read a value for each counter.

Software reads the counters while they run, and a live count could change between the two byte reads. To avoid that, the block has a capture function. A selected edge of a selected capture source copies both counters into shadow registers in the same clock cycle and raises a sticky interrupt. While capture is enabled, the read outputs show the shadow contents instead of the live counts.

The capture source is one of two internal ticks (1 kHz and 32 kHz) or one of two external pins. The source is passed through a synchronizer into the counter clock domain before edge detection. The prescaler that makes the ticks lies outside the block.

Top module: `twin_counter_capture`

## Requirements
- R1: `cap_src` selects the capture signal with this encoding: 0 is `tick_1k`, 1 is `ext_pin2`, 2 is `ext_pin3`, 3 is `tick_32k`. Edges on the sources that are not selected never cause a capture.
- R2: `cap_mode` sets the capture condition for every source with this encoding: 0 is off (no capture), 1 is rising edges, 2 is falling edges, 3 is both edges.
- R3: One capture event copies counter A into shadow A and counter B into shadow B in the same clock cycle. Each shadow takes the count held just before that edge. Between events the shadows keep their value.
- R4: When `cap_mode` is nonzero, `rd_a`/`rd_b` return the shadow registers. When `cap_mode` is 0, they return the live counts.
- R5: `irq` is set by every capture event and stays set until a one-cycle `irq_clr` pulse clears it. A new capture while `irq` is set overwrites the shadows and keeps `irq` set. A capture and a clear in the same cycle leave `irq` set.
- R6: In split mode (`cascade`=0), a counter counting up steps by one on each clock while `run`=1 and wraps from 0xFF to 0x00.
- R7: In split mode, a counter counting down (`down_x`=1) steps down by one and wraps from 0x00 to 0xFF.
- R8: With `cascade`=1, A is the low byte and B the high byte of one 16-bit counter whose direction is `down_a`. B steps only when A wraps. The 16-bit value wraps 0xFFFF to 0x0000 going up and 0x0000 to 0xFFFF going down.
- R9: With the default two synchronizer stages, `irq` rises at the third rising clock edge that samples the new level of the selected source. It is still low after the second such edge.
- R10: After reset, both counters, both shadows and `irq` are zero. A `wr_x` pulse loads `wr_data_x` into that counter at the next edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counters step on each clock while high |
| cascade | input | 1 | 1: A and B form one 16-bit counter |
| down_a | input | 1 | Direction of counter A (1 = down); direction of the chained counter |
| down_b | input | 1 | Direction of counter B in split mode |
| wr_a | input | 1 | Load counter A |
| wr_b | input | 1 | Load counter B |
| wr_data_a | input | 8 | Load value for A |
| wr_data_b | input | 8 | Load value for B |
| tick_1k | input | 1 | Internal 1 kHz capture tick |
| tick_32k | input | 1 | Internal 32 kHz capture tick |
| ext_pin2 | input | 1 | External capture pin, asynchronous |
| ext_pin3 | input | 1 | External capture pin, asynchronous |
| cap_src | input | 2 | Capture source select |
| cap_mode | input | 2 | Capture edge mode |
| irq_clr | input | 1 | Write-one-to-clear pulse for `irq` |
| rd_a | output | 8 | Read value of counter A (shadow or live) |
| rd_b | output | 8 | Read value of counter B (shadow or live) |
| irq | output | 1 | Sticky capture interrupt |

## Verification
The assertions assume that `cap_src`, `cap_mode` and `cascade` are changed only while `run` is low. They also assume that `irq_clr` is a single-cycle pulse. The bench follows both rules: every task sets the configuration with the counters stopped and then lets the synchronizer settle for several cycles before it makes an edge. Source levels change half a cycle away from the clock edge, so the latency check has a fixed edge count.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   typedef enum logic [1:0] {
      SRC_TICK_SLOW = 2'b00,
      SRC_PIN_2     = 2'b01,
      SRC_PIN_3     = 2'b10,
      SRC_TICK_FAST = 2'b11
   } cap_src_e;

   typedef enum logic [1:0] {
      CAPM_OFF  = 2'b00,
      CAPM_RISE = 2'b01,
      CAPM_FALL = 2'b10,
      CAPM_BOTH = 2'b11
   } cap_mode_e;
endpackage

// File: rtl/tcc_edge_detect.sv
module tcc_edge_detect
   import tcc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src_sel,
   input  logic [1:0] mode,
   input  logic       tick_1k,
   input  logic       tick_32k,
   input  logic       ext_pin2,
   input  logic       ext_pin3,
   output logic       cap_evt
);
   localparam int LAST = SYNC_STAGES - 1;

   logic                   raw_sel;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   lvl;

   always_comb begin
      unique case (cap_src_e'(src_sel))
         SRC_TICK_SLOW: raw_sel = tick_1k;
         SRC_PIN_2:     raw_sel = ext_pin2;
         SRC_PIN_3:     raw_sel = ext_pin3;
         default:       raw_sel = tick_32k;
      endcase
   end

   // synchronizer chain, one flop per stage
   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= raw_sel;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
         end
      end
   endgenerate

   assign lvl = sync_q[LAST];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;

   always_comb begin
      unique case (cap_mode_e'(mode))
         CAPM_RISE: cap_evt = lvl & ~prev_q;
         CAPM_FALL: cap_evt = ~lvl & prev_q;
         CAPM_BOTH: cap_evt = lvl ^ prev_q;
         default:   cap_evt = 1'b0;
      endcase
   end
endmodule

// File: rtl/tcc_counter_pair.sv
module tcc_counter_pair #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cascade,
   input  logic             down_a,
   input  logic             down_b,
   input  logic             wr_a,
   input  logic             wr_b,
   input  logic [CNT_W-1:0] wr_data_a,
   input  logic [CNT_W-1:0] wr_data_b,
   output logic [CNT_W-1:0] cnt_a,
   output logic [CNT_W-1:0] cnt_b
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

   logic a_wrap, step_b, dir_b;

   assign a_wrap = down_a ? (cnt_a == '0) : (cnt_a == CMAX);
   assign dir_b  = cascade ? down_a : down_b;
   assign step_b = run & (~cascade | a_wrap);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     cnt_a <= '0;
      else if (wr_a)  cnt_a <= wr_data_a;
      else if (run)   cnt_a <= down_a ? cnt_a - CONE : cnt_a + CONE;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      cnt_b <= '0;
      else if (wr_b)   cnt_b <= wr_data_b;
      else if (step_b) cnt_b <= dir_b ? cnt_b - CONE : cnt_b + CONE;
endmodule

// File: rtl/tcc_shadow_irq.sv
module tcc_shadow_irq #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_evt,
   input  logic             irq_clr,
   input  logic [CNT_W-1:0] cnt_a,
   input  logic [CNT_W-1:0] cnt_b,
   output logic [CNT_W-1:0] shad_a,
   output logic [CNT_W-1:0] shad_b,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         shad_a <= '0;
         shad_b <= '0;
      end else if (cap_evt) begin
         shad_a <= cnt_a;
         shad_b <= cnt_b;
      end

   // set wins over clear
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       irq <= 1'b0;
      else if (cap_evt) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
endmodule

// File: rtl/twin_counter_capture.sv
module twin_counter_capture #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             cascade,
   input  logic             down_a,
   input  logic             down_b,
   input  logic             wr_a,
   input  logic             wr_b,
   input  logic [CNT_W-1:0] wr_data_a,
   input  logic [CNT_W-1:0] wr_data_b,
   input  logic             tick_1k,
   input  logic             tick_32k,
   input  logic             ext_pin2,
   input  logic             ext_pin3,
   input  logic [1:0]       cap_src,
   input  logic [1:0]       cap_mode,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] rd_a,
   output logic [CNT_W-1:0] rd_b,
   output logic             irq
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("twin_counter_capture: CNT_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("twin_counter_capture: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             cap_evt;
   logic             cap_on;
   logic [CNT_W-1:0] cnt_a, cnt_b, shad_a, shad_b;

   tcc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .src_sel(cap_src), .mode(cap_mode),
      .tick_1k(tick_1k), .tick_32k(tick_32k),
      .ext_pin2(ext_pin2), .ext_pin3(ext_pin3), .cap_evt(cap_evt)
   );

   tcc_counter_pair #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .cascade(cascade),
      .down_a(down_a), .down_b(down_b), .wr_a(wr_a), .wr_b(wr_b),
      .wr_data_a(wr_data_a), .wr_data_b(wr_data_b),
      .cnt_a(cnt_a), .cnt_b(cnt_b)
   );

   tcc_shadow_irq #(.CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .irq_clr(irq_clr),
      .cnt_a(cnt_a), .cnt_b(cnt_b), .shad_a(shad_a), .shad_b(shad_b),
      .irq(irq)
   );

   assign cap_on = |cap_mode;
   assign rd_a   = cap_on ? shad_a : cnt_a;
   assign rd_b   = cap_on ? shad_b : cnt_b;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             cascade,
   input logic             down_a,
   input logic             down_b,
   input logic             wr_a,
   input logic             wr_b,
   input logic [1:0]       cap_mode,
   input logic             cap_evt,
   input logic             irq_clr,
   input logic             irq,
   input logic [CNT_W-1:0] cnt_a,
   input logic [CNT_W-1:0] cnt_b,
   input logic [CNT_W-1:0] shad_a,
   input logic [CNT_W-1:0] shad_b
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   p_off_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode == 2'b00 |-> !cap_evt);

   p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt |=> ($stable(shad_a) && $stable(shad_b)));

   p_shadow_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (shad_a == $past(cnt_a) && shad_b == $past(cnt_b)));

   p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> irq);

   p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   p_up_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cascade && !down_a && !wr_a && cnt_a == CMAX) |=> cnt_a == '0);

   p_down_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cascade && down_b && !wr_b && cnt_b == '0) |=> cnt_b == CMAX);

   p_casc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cascade && !wr_b &&
       ((!down_a && cnt_a != CMAX) || (down_a && cnt_a != '0)))
      |=> $stable(cnt_b));
endmodule

bind twin_counter_capture tcc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .cascade(cascade),
   .down_a(down_a), .down_b(down_b), .wr_a(wr_a), .wr_b(wr_b),
   .cap_mode(cap_mode), .cap_evt(cap_evt), .irq_clr(irq_clr), .irq(irq),
   .cnt_a(cnt_a), .cnt_b(cnt_b), .shad_a(shad_a), .shad_b(shad_b)
);

// File: tb/twin_counter_capture_tb_top.sv
`timescale 1ns/1ps
module twin_counter_capture_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 0, cascade = 0, down_a = 0, down_b = 0;
   logic       wr_a = 0, wr_b = 0;
   logic [7:0] wr_data_a = 0, wr_data_b = 0;
   logic       tick_1k = 0, tick_32k = 0, ext_pin2 = 0, ext_pin3 = 0;
   logic [1:0] cap_src = 0, cap_mode = 0;
   logic       irq_clr = 0;
   logic [7:0] rd_a, rd_b;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   twin_counter_capture dut_i (
      .clk(clk), .rst_n(rst_n), .run(run), .cascade(cascade),
      .down_a(down_a), .down_b(down_b), .wr_a(wr_a), .wr_b(wr_b),
      .wr_data_a(wr_data_a), .wr_data_b(wr_data_b),
      .tick_1k(tick_1k), .tick_32k(tick_32k),
      .ext_pin2(ext_pin2), .ext_pin3(ext_pin3),
      .cap_src(cap_src), .cap_mode(cap_mode), .irq_clr(irq_clr),
      .rd_a(rd_a), .rd_b(rd_b), .irq(irq)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input logic [7:0] a, input logic [7:0] b);
      wr_a = 1; wr_b = 1; wr_data_a = a; wr_data_b = b;
      cyc(1);
      wr_a = 0; wr_b = 0;
   endtask

   task automatic clear_irq();
      irq_clr = 1;
      cyc(1);
      irq_clr = 0;
   endtask

   task automatic set_src(input int s, input logic v);
      case (s)
         0: tick_1k  = v;
         1: ext_pin2 = v;
         2: ext_pin3 = v;
         default: tick_32k = v;
      endcase
   endtask

   task automatic t_reset();
      chk("R10 reset rd_a", {8'h0, rd_a}, 16'h0);
      chk("R10 reset rd_b", {8'h0, rd_b}, 16'h0);
      chk("R10 reset irq", {15'h0, irq}, 16'h0);
   endtask

   task automatic t_load();
      cap_mode = 0;
      load(8'h3C, 8'hC3);
      chk("R10 load A / R4 live read", {8'h0, rd_a}, 16'h003C);
      chk("R10 load B / R4 live read", {8'h0, rd_b}, 16'h00C3);
      run = 1; wr_a = 1; wr_data_a = 8'h11;
      cyc(1);
      wr_a = 0; run = 0;
      chk("R10 write beats counting", {8'h0, rd_a}, 16'h0011);
      chk("R10 B counts while A loads", {8'h0, rd_b}, 16'h00C4);
   endtask

   task automatic t_split_up();
      cascade = 0; down_a = 0; down_b = 0;
      load(8'hFE, 8'h7F);
      run = 1; cyc(3); run = 0;
      chk("R6 A wraps FF->00", {8'h0, rd_a}, 16'h0001);
      chk("R6 B independent up", {8'h0, rd_b}, 16'h0082);
   endtask

   task automatic t_split_down();
      cascade = 0; down_a = 1; down_b = 1;
      load(8'h01, 8'h00);
      run = 1; cyc(2); run = 0;
      chk("R7 A wraps 00->FF", {8'h0, rd_a}, 16'h00FF);
      chk("R7 B wraps 00->FF", {8'h0, rd_b}, 16'h00FE);
      down_a = 0; down_b = 0;
   endtask

   task automatic t_cascade();
      cascade = 1; down_a = 0; down_b = 1;
      load(8'hFE, 8'h12);
      run = 1; cyc(3); run = 0;
      chk("R8 cascade up carry", {rd_b, rd_a}, 16'h1301);
      down_a = 1; down_b = 0;
      load(8'h01, 8'h00);
      run = 1; cyc(3); run = 0;
      chk("R8 cascade down wraps to FFFF", {rd_b, rd_a}, 16'hFFFE);
      down_a = 0; down_b = 0; cascade = 0;
   endtask

   task automatic t_sources();
      cascade = 0;
      load(8'h5A, 8'hA5);
      cap_mode = 2'b01;
      for (int s = 0; s < 4; s++) begin
         int o;
         o = (s + 1) % 4;
         cap_src = 2'(s);
         cyc(5);
         clear_irq();
         set_src(o, 1); cyc(5);
         chk($sformatf("R1 unselected %0d ignored (sel %0d)", o, s), {15'h0, irq}, 16'h0);
         set_src(o, 0); cyc(5);
         set_src(s, 1); cyc(5);
         chk($sformatf("R1 source %0d captures", s), {15'h0, irq}, 16'h1);
         chk($sformatf("R1/R4 shadow read sel %0d", s), {rd_b, rd_a}, 16'hA55A);
         set_src(s, 0); cyc(5);
         clear_irq();
      end
   endtask

   task automatic t_modes();
      cap_src = 2'b01;
      cap_mode = 2'b10; cyc(5); clear_irq();
      ext_pin2 = 1; cyc(5);
      chk("R2 falling mode ignores rise", {15'h0, irq}, 16'h0);
      ext_pin2 = 0; cyc(5);
      chk("R2 falling mode captures fall", {15'h0, irq}, 16'h1);
      clear_irq();
      cap_mode = 2'b11;
      ext_pin2 = 1; cyc(5);
      chk("R2 both mode rise", {15'h0, irq}, 16'h1);
      clear_irq();
      ext_pin2 = 0; cyc(5);
      chk("R2 both mode fall", {15'h0, irq}, 16'h1);
      clear_irq();
      cap_mode = 2'b00;
      load(8'h77, 8'h66);
      ext_pin2 = 1; cyc(5); ext_pin2 = 0; cyc(5);
      chk("R2 off mode no capture", {15'h0, irq}, 16'h0);
      chk("R4 off mode reads live", {rd_b, rd_a}, 16'h6677);
   endtask

   task automatic t_latency();
      cap_src = 2'b10; cap_mode = 2'b01; cyc(5); clear_irq();
      ext_pin3 = 1;
      cyc(2);
      chk("R9 irq low after second edge", {15'h0, irq}, 16'h0);
      cyc(1);
      chk("R9 irq high after third edge", {15'h0, irq}, 16'h1);
      ext_pin3 = 0; cyc(5);
   endtask

   task automatic t_irq_w1c();
      cap_src = 2'b01; cap_mode = 2'b01; cyc(4); clear_irq();
      load(8'h21, 8'h43);
      ext_pin2 = 1; cyc(5); ext_pin2 = 0;
      cyc(6);
      chk("R5 irq sticky", {15'h0, irq}, 16'h1);
      load(8'h99, 8'h88);
      ext_pin2 = 1; cyc(5); ext_pin2 = 0; cyc(4);
      chk("R5 shadows overwritten while set", {rd_b, rd_a}, 16'h8899);
      chk("R5 irq stays set", {15'h0, irq}, 16'h1);
      clear_irq();
      chk("R5 clear pulse", {15'h0, irq}, 16'h0);
      ext_pin2 = 1; cyc(2);
      irq_clr = 1; cyc(1); irq_clr = 0;
      chk("R5 capture wins over clear", {15'h0, irq}, 16'h1);
      ext_pin2 = 0; cyc(5); clear_irq();
   endtask

   task automatic t_capture_running();
      cascade = 1; down_a = 0;
      cap_src = 2'b01; cap_mode = 2'b01;
      load(8'hFF, 8'hFF);
      cyc(4); clear_irq();
      run = 1; ext_pin2 = 1;
      cyc(3);
      run = 0;
      chk("R3 both bytes latched together", {rd_b, rd_a}, 16'h0001);
      chk("R3 irq on running capture", {15'h0, irq}, 16'h1);
      cap_mode = 2'b00;
      cyc(1);
      chk("R4 live value after capture", {rd_b, rd_a}, 16'h0002);
      ext_pin2 = 0; cascade = 0; cyc(3); clear_irq();
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      t_reset();
      t_load();
      t_split_up();
      t_split_down();
      t_cascade();
      t_sources();
      t_modes();
      t_latency();
      t_irq_w1c();
      t_capture_running();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule